// File: doc/BRIEF.md
# Deadline-Grouped DMA Channel Arbiter

This block chooses one DMA channel to serve from up to sixteen requesters. Each channel arrives with two 8-bit values: a running count and a threshold. The difference between them is the time the channel has left before its deadline. The block sorts every requesting channel into one of four urgency groups based on that slack. The most urgent non-empty group always wins. Inside the winning group, channels take turns in round-robin order. Each group keeps its own rotation pointer, so serving an urgent channel does not disturb the order inside the relaxed groups.

The result leaves the block as a registered grant stream. `gnt_valid_o` qualifies a one-hot grant vector, the winner's channel index and the winner's group. The consumer takes the grant by raising `gnt_ready_i`.

Back-pressure works as follows:
- While `gnt_valid_o` is high and `gnt_ready_i` is low, every grant output holds its value and no rotation pointer moves.
- A transfer completes on a clock edge where both signals are high.
- On any edge where the output is empty or being taken, the register loads a fresh decision from the inputs present at that edge.
- If no channel requests at such an edge, `gnt_valid_o` drops.

Top module: `dl_arb`

## Requirements
- R1: Slack is count minus threshold. When the count is below the threshold, the slack is taken as 0.
- R2: Slack 0..1 gives group 0. Slack 2..7 gives group 1. Slack 8..63 gives group 2. Slack 64..255 gives group 3. `gnt_grp_o` carries the group number as a 2-bit binary value.
- R3: When requesting channels sit in different groups, the grant goes to a channel from the lowest-numbered non-empty group.
- R4: Within a group, the search starts at that group's pointer and moves upward through the channel numbers, wrapping around. After reset every pointer is at channel 0, so the lowest-numbered requester wins ties. An accepted grant moves that group's pointer to the channel after the winner.
- R5: An accepted grant moves only the pointer of the winner's group. The pointers of the other groups keep their values.
- R6: A channel whose request bit is low is never granted. If no channel requests on a load edge, `gnt_valid_o` is 0 and `gnt_onehot_o` is all zeros.
- R7: While `gnt_valid_o`=1 and `gnt_ready_i`=0, the valid, one-hot, index and group outputs stay unchanged, and no pointer advances.
- R8: The decision is registered. Inputs present at a load edge appear on the outputs after that edge. When valid, `gnt_onehot_o` has exactly bit `gnt_idx_o` set.
- R9: During reset `gnt_valid_o` is 0 and `gnt_onehot_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_CH | Per-channel request bits |
| count_i | input | N_CH*8 | Current counts; channel c occupies bits [8c+7:8c] |
| thresh_i | input | N_CH*8 | Thresholds, packed the same way as `count_i` |
| gnt_ready_i | input | 1 | Consumer accepts the current grant |
| gnt_valid_o | output | 1 | A grant is being presented |
| gnt_onehot_o | output | N_CH | One-hot grant vector |
| gnt_idx_o | output | 4 | Index of the granted channel |
| gnt_grp_o | output | 2 | Urgency group of the granted channel |

## Verification
Grouping is tried with one channel at a time, set to slack values on each side of every bin edge and with a count below its threshold. This separates off-by-one errors in the bin limits from wrong handling of the subtraction. Mixed-group patterns show that urgency beats rotation. Repeated same-group requests with ready held high reveal the rotation order and its wrap-around. Alternating grants between two groups show whether one group's pointer leaks into another's.

Stalled cycles, during which the inputs keep changing, show that the held grant and the pointers freeze. A long stretch of random requests, counts and ready values is compared against a cycle model. That stretch catches interactions, such as taking a grant on the same edge a new decision is loaded.

// File: rtl/dl_arb_pkg.sv
package dl_arb_pkg;
  localparam int NUM_GRP = 4;
  localparam int GRP_W   = 2;
  typedef logic [GRP_W-1:0] grp_t;
endpackage

// File: rtl/dl_grouper.sv
module dl_grouper
  import dl_arb_pkg::*;
#(
  parameter int N_CH = 16,
  parameter int CW   = 8,
  parameter int LIM1 = 2,
  parameter int LIM2 = 8,
  parameter int LIM3 = 64
) (
  input  logic [N_CH-1:0]              req,
  input  logic [N_CH*CW-1:0]           cnt,
  input  logic [N_CH*CW-1:0]           thr,
  output logic [N_CH*GRP_W-1:0]        ch_grp,
  output logic [NUM_GRP-1:0][N_CH-1:0] grp_req
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [CW-1:0] cv, tv, slack;
    grp_t          grp;
    assign cv = cnt[c*CW +: CW];
    assign tv = thr[c*CW +: CW];

    // Saturate negative slack at zero.
    always_comb begin
      if (cv >= tv) slack = cv - tv;
      else          slack = '0;
    end

    always_comb begin
      if (slack < CW'(LIM1))      grp = grp_t'(0);
      else if (slack < CW'(LIM2)) grp = grp_t'(1);
      else if (slack < CW'(LIM3)) grp = grp_t'(2);
      else                        grp = grp_t'(3);
    end

    assign ch_grp[c*GRP_W +: GRP_W] = grp;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_mask
      assign grp_req[g][c] = req[c] && (grp == grp_t'(g));
    end
  end
endmodule

// File: rtl/dl_rr_pick.sv
module dl_rr_pick #(
  parameter int N_CH = 16,
  localparam int IW  = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] req,
  input  logic [IW-1:0]   ptr,
  output logic            found,
  output logic [IW-1:0]   idx
);
  // Walk downward so that the last hit written is the first one in rotation order.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N_CH - 1; k >= 0; k--) begin
      int cand;
      cand = int'(ptr) + k;
      if (cand >= N_CH) cand = cand - N_CH;
      if (req[cand]) begin
        found = 1'b1;
        idx   = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/dl_grp_select.sv
module dl_grp_select
  import dl_arb_pkg::*;
#(
  parameter int N_CH = 16,
  localparam int IW  = $clog2(N_CH)
) (
  input  logic [NUM_GRP-1:0]         found,
  input  logic [NUM_GRP-1:0][IW-1:0] idx,
  output logic                       any,
  output grp_t                       win_grp,
  output logic [IW-1:0]              win_idx
);
  // Fixed priority: group 0 is the most urgent.
  always_comb begin
    any     = 1'b0;
    win_grp = '0;
    win_idx = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if (found[g]) begin
        any     = 1'b1;
        win_grp = grp_t'(g);
        win_idx = idx[g];
      end
    end
  end
endmodule

// File: rtl/dl_arb.sv
module dl_arb
  import dl_arb_pkg::*;
#(
  parameter int N_CH = 16,
  parameter int CW   = 8,
  parameter int LIM1 = 2,
  parameter int LIM2 = 8,
  parameter int LIM3 = 64,
  localparam int IW  = $clog2(N_CH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_CH-1:0]      req_i,
  input  logic [N_CH*CW-1:0]   count_i,
  input  logic [N_CH*CW-1:0]   thresh_i,
  input  logic                 gnt_ready_i,
  output logic                 gnt_valid_o,
  output logic [N_CH-1:0]      gnt_onehot_o,
  output logic [IW-1:0]        gnt_idx_o,
  output logic [GRP_W-1:0]     gnt_grp_o
);
  logic [N_CH*GRP_W-1:0]        ch_grp;
  logic [NUM_GRP-1:0][N_CH-1:0] grp_req;
  logic [NUM_GRP-1:0]           grp_found;
  logic [NUM_GRP-1:0][IW-1:0]   grp_idx;
  logic [NUM_GRP-1:0][IW-1:0]   ptr_q, ptr_eff;
  logic                         any;
  grp_t                         win_grp;
  logic [IW-1:0]                win_idx;
  logic                         fire, load;

  logic                         valid_q;
  logic [N_CH-1:0]              onehot_q;
  logic [IW-1:0]                idx_q;
  grp_t                         grp_q;

  assign fire = valid_q && gnt_ready_i;
  assign load = !valid_q || gnt_ready_i;

  dl_grouper #(.N_CH(N_CH), .CW(CW), .LIM1(LIM1), .LIM2(LIM2), .LIM3(LIM3)) u_grouper (
    .req     (req_i),
    .cnt     (count_i),
    .thr     (thresh_i),
    .ch_grp  (ch_grp),
    .grp_req (grp_req)
  );

  // The pointer in use already reflects a grant taken on this same edge.
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [IW-1:0] nxt;
    assign nxt = (idx_q == IW'(N_CH - 1)) ? '0 : idx_q + 1'b1;
    assign ptr_eff[g] = (fire && grp_q == grp_t'(g)) ? nxt : ptr_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) ptr_q[g] <= '0;
      else        ptr_q[g] <= ptr_eff[g];
    end

    dl_rr_pick #(.N_CH(N_CH)) u_pick (
      .req   (grp_req[g]),
      .ptr   (ptr_eff[g]),
      .found (grp_found[g]),
      .idx   (grp_idx[g])
    );
  end

  dl_grp_select #(.N_CH(N_CH)) u_sel (
    .found   (grp_found),
    .idx     (grp_idx),
    .any     (any),
    .win_grp (win_grp),
    .win_idx (win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      onehot_q <= '0;
      idx_q    <= '0;
      grp_q    <= '0;
    end else if (load) begin
      valid_q  <= any;
      onehot_q <= any ? (N_CH'(1) << win_idx) : '0;
      idx_q    <= win_idx;
      grp_q    <= win_grp;
    end
  end

  assign gnt_valid_o  = valid_q;
  assign gnt_onehot_o = onehot_q;
  assign gnt_idx_o    = idx_q;
  assign gnt_grp_o    = grp_q;
endmodule

// File: rtl/dl_arb_chk.sv
module dl_arb_chk
  import dl_arb_pkg::*;
#(
  parameter int N_CH = 16,
  localparam int IW  = $clog2(N_CH)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_CH-1:0]       req_i,
  input logic                  gnt_ready_i,
  input logic                  gnt_valid_o,
  input logic [N_CH-1:0]       gnt_onehot_o,
  input logic [IW-1:0]         gnt_idx_o,
  input logic [GRP_W-1:0]      gnt_grp_o,
  input logic [N_CH*GRP_W-1:0] ch_grp
);
  logic       ld;
  logic       any_req;
  logic [1:0] min_grp;

  assign ld = !gnt_valid_o || gnt_ready_i;

  always_comb begin
    any_req = |req_i;
    min_grp = 2'd3;
    for (int c = 0; c < N_CH; c++) begin
      if (req_i[c] && ch_grp[c*GRP_W +: GRP_W] < min_grp) min_grp = ch_grp[c*GRP_W +: GRP_W];
    end
  end

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> ($countones(gnt_onehot_o) == 1 && gnt_onehot_o[gnt_idx_o]));

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid_o |-> gnt_onehot_o == '0);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && !gnt_ready_i) |=>
      (gnt_valid_o && $stable(gnt_onehot_o) && $stable(gnt_idx_o) && $stable(gnt_grp_o)));

  assert_req_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (!gnt_valid_o || ($past(req_i) & gnt_onehot_o) != '0));

  assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !any_req) |=> !gnt_valid_o);

  assert_urgent_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && any_req) |=> (gnt_valid_o && gnt_grp_o == $past(min_grp)));
endmodule

bind dl_arb dl_arb_chk #(.N_CH(N_CH)) u_dl_arb_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .gnt_ready_i  (gnt_ready_i),
  .gnt_valid_o  (gnt_valid_o),
  .gnt_onehot_o (gnt_onehot_o),
  .gnt_idx_o    (gnt_idx_o),
  .gnt_grp_o    (gnt_grp_o),
  .ch_grp       (ch_grp)
);

// File: tb/test_dl_arb.sv
module test_dl_arb;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic [N*8-1:0] count_i = '0;
  logic [N*8-1:0] thresh_i = '0;
  logic          gnt_ready_i = 1'b0;
  logic          gnt_valid_o;
  logic [N-1:0]  gnt_onehot_o;
  logic [3:0]    gnt_idx_o;
  logic [1:0]    gnt_grp_o;

  always #4 clk = ~clk;  // 125 MHz

  dl_arb i_dl_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .count_i(count_i), .thresh_i(thresh_i),
    .gnt_ready_i(gnt_ready_i), .gnt_valid_o(gnt_valid_o), .gnt_onehot_o(gnt_onehot_o),
    .gnt_idx_o(gnt_idx_o), .gnt_grp_o(gnt_grp_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] cnt_a [N];
  logic [7:0] thr_a [N];

  // Cycle model state
  bit       m_valid = 0;
  int       m_idx = 0;
  int       m_grp = 0;
  int       m_ptr [4] = '{0, 0, 0, 0};

  logic [6:0] exp_q [$];   // {valid, grp[1:0], idx[3:0]}
  string      tag_q [$];

  function automatic int slack_grp(logic [7:0] c, logic [7:0] t);
    int s;
    s = (c >= t) ? int'(c) - int'(t) : 0;
    if (s <= 1) return 0;
    if (s <= 7) return 1;
    if (s <= 63) return 2;
    return 3;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the model's expected output.
  task automatic apply(logic [N-1:0] r, logic rdy, string tag);
    int ep [4];
    bit fnd;
    @(negedge clk);
    req_i = r;
    gnt_ready_i = rdy;
    for (int c = 0; c < N; c++) begin
      count_i[c*8 +: 8]  = cnt_a[c];
      thresh_i[c*8 +: 8] = thr_a[c];
    end
    for (int g = 0; g < 4; g++) ep[g] = m_ptr[g];
    if (m_valid && rdy) ep[m_grp] = (m_idx + 1) % N;
    if (!m_valid || rdy) begin
      fnd = 0;
      for (int g = 0; g < 4 && !fnd; g++)
        for (int k = 0; k < N && !fnd; k++) begin
          int c;
          c = (ep[g] + k) % N;
          if (r[c] && slack_grp(cnt_a[c], thr_a[c]) == g) begin
            fnd = 1; m_idx = c; m_grp = g;
          end
        end
      m_valid = fnd;
    end
    for (int g = 0; g < 4; g++) m_ptr[g] = ep[g];
    exp_q.push_back({m_valid, 2'(m_grp), 4'(m_idx)});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " valid"}, int'(gnt_valid_o), int'(e[6]));
        if (e[6]) begin
          check({t, " idx"}, int'(gnt_idx_o), int'(e[3:0]));
          check({t, " grp"}, int'(gnt_grp_o), int'(e[5:4]));
          check({t, " onehot R8"}, int'(gnt_onehot_o), int'(N'(1) << e[3:0]));
        end else begin
          check({t, " onehot idle R6"}, int'(gnt_onehot_o), 0);
        end
      end
    end
  end

  task automatic set_all(logic [7:0] c, logic [7:0] t);
    for (int i = 0; i < N; i++) begin cnt_a[i] = c; thr_a[i] = t; end
  endtask

  initial begin
    set_all(8'd200, 8'd0);
    repeat (3) @(negedge clk);
    check("R9 reset valid", int'(gnt_valid_o), 0);
    check("R9 reset onehot", int'(gnt_onehot_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R2: bin edges, one channel at a time
    begin
      int sl [8] = '{0, 1, 2, 7, 8, 63, 64, 255};
      for (int i = 0; i < 8; i++) begin
        cnt_a[3] = 8'(sl[i]); thr_a[3] = 8'd0;
        apply(16'h0008, 1'b1, "R2 bin edge");
      end
    end
    cnt_a[3] = 8'd10; thr_a[3] = 8'd90;
    apply(16'h0008, 1'b1, "R1 count below threshold");
    cnt_a[3] = 8'd90; thr_a[3] = 8'd10;
    apply(16'h0008, 1'b1, "R1 slack 80");

    // R2: slack 100, 175, 175, 80 all share group 3
    cnt_a[0] = 100; thr_a[0] = 0;
    cnt_a[1] = 255; thr_a[1] = 80;
    cnt_a[2] = 255; thr_a[2] = 80;
    cnt_a[3] = 240; thr_a[3] = 160;
    for (int i = 0; i < 5; i++) apply(16'h000F, 1'b1, "R2 shared group rotation");

    // R3: urgent channel beats lower-numbered relaxed one
    set_all(8'd200, 8'd0);
    cnt_a[9] = 8'd1; thr_a[9] = 8'd0;
    cnt_a[5] = 8'd20; thr_a[5] = 8'd0;
    apply(16'h0220, 1'b1, "R3 group 0 over group 2");
    apply(16'h0220, 1'b1, "R3 repeat");

    // R4: rotation with wrap in group 3
    set_all(8'd200, 8'd0);
    for (int i = 0; i < 6; i++) apply(16'h8092, 1'b1, "R4 rotation wrap");

    // R5: alternating groups keep separate pointers
    cnt_a[2] = 8'd5; thr_a[2] = 8'd0;
    cnt_a[6] = 8'd5; thr_a[6] = 8'd0;
    apply(16'h0044, 1'b1, "R5 group 1 grant");
    apply(16'h0011, 1'b1, "R5 group 3 untouched");
    apply(16'h0044, 1'b1, "R5 group 1 next");
    apply(16'h0011, 1'b1, "R5 group 3 still");

    // R7: stall with changing inputs
    apply(16'h0300, 1'b0, "R7 load under stall");
    apply(16'h0001, 1'b0, "R7 hold");
    apply(16'h0000, 1'b0, "R7 hold empty req");
    apply(16'h0300, 1'b1, "R7 release");
    apply(16'h0300, 1'b1, "R7 pointer after release");

    // R6: no requests
    apply(16'h0000, 1'b1, "R6 no request");
    apply(16'h0000, 1'b0, "R6 idle no ready");

    // R8: random mix against the model
    for (int i = 0; i < 400; i++) begin
      for (int c = 0; c < N; c++) begin
        cnt_a[c] = 8'($urandom);
        thr_a[c] = ($urandom % 3 == 0) ? 8'($urandom) : cnt_a[c] - 8'($urandom % 12);
      end
      apply(16'($urandom) & 16'($urandom), ($urandom % 4) != 0, "R8 random");
    end
    apply(16'h0000, 1'b1, "R6 drain");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule